// File: doc/BRIEF.md
# CRT Controller Host Register File

This block is the processor-facing register file of a character-based CRT timing controller. The host first writes a register number into a select latch. Later data writes go to the selected register, and each register keeps only the bits that are defined for it. The stored values are split into named timing fields that feed the timing generator: horizontal and vertical totals, displayed counts, sync positions and widths, row and cursor geometry, interlace mode, display skew, start address and cursor address.

The block also contains a light pen latch. A strobe captures the live refresh address from the timing generator and raises a flag. The flag can be read in the status byte, and reading either half of the captured address clears it. Most timing registers are write-only, so reading one of them returns all ones.

The interface is synchronous and single-cycle. A read presents its data on `rdata_o` on the clock edge that samples the read strobe. An access of the select latch with `rs_i` low, `cs_i` high and `rd_i` high returns the status byte.

Top module: `crtc_regfile`

## Requirements
- R1: A write with `cs_i`=1, `wr_i`=1 and `rs_i`=0 loads `wdata_i[4:0]` into the register select.
- R2: A write with `cs_i`=1, `wr_i`=1 and `rs_i`=1 stores `wdata_i` into the selected register through a mask:
  - registers 4, 6, 7 and 10 keep bits 6:0;
  - registers 5, 9 and 11 keep bits 4:0;
  - registers 12 and 14 keep bits 5:0;
  - registers 0 to 3, 8, 13 and 15 keep all 8 bits.
  Register 10 drives `cursor_start_o` from bits 4:0 and `cursor_mode_o` from bits 6:5. Registers 12/13 form `start_addr_o` (high/low) and registers 14/15 form `cursor_addr_o` (high/low).
- R3: Register 3 drives `h_sync_width_o` from bits 3:0 and `v_sync_lines_o` from bits 7:4.
- R4: A read with `rs_i`=1 of registers 12 to 17 returns their stored value. A read of any other select value returns 8'hFF.
- R5: While `lpen_i` is high at a clock edge, `refresh_addr_i[13:8]` is captured into register 16 (zero-extended) and `refresh_addr_i[7:0]` into register 17, and status bit 6 is set.
- R6: A read of register 16 or 17 clears status bit 6. A light pen strobe in the same cycle keeps the bit set.
- R7: A status read (`rs_i`=0, `rd_i`=1) returns bit 6 = light pen flag, bit 5 = `vsync_i`, and all other bits 0.
- R8: Register 8 bits 1:0 drive `interlace_o`: 01 gives 1 (sync only), 11 gives 2 (sync and video), and any other value gives 0 (off).
- R9: Register 8 bits 5:4 drive `skew_o`: 00 gives 0, 01 gives 1, 10 gives 2, and 11 gives 0.
- R10: Data writes while the select is 16 to 31 change no register and no output field.
- R11: After reset, all registers, the select, the light pen flag and `rdata_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select |
| rs_i | input | 1 | 0 = select/status, 1 = data register |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| lpen_i | input | 1 | Light pen strobe |
| refresh_addr_i | input | 14 | Live refresh address from the timing generator |
| vsync_i | input | 1 | Vertical sync from the timing generator |
| h_total_o | output | 8 | Horizontal total |
| h_disp_o | output | 8 | Horizontal displayed |
| h_sync_pos_o | output | 8 | Horizontal sync position |
| h_sync_width_o | output | 4 | Horizontal sync width |
| v_sync_lines_o | output | 4 | Vertical sync line count |
| v_total_o | output | 7 | Vertical total |
| v_adjust_o | output | 5 | Vertical total adjust |
| v_disp_o | output | 7 | Vertical displayed |
| v_sync_pos_o | output | 7 | Vertical sync position |
| interlace_o | output | 2 | Interlace mode: 0 off, 1 sync, 2 sync and video |
| skew_o | output | 2 | Display skew in characters |
| max_row_o | output | 5 | Last scan line of a character row |
| cursor_start_o | output | 5 | Cursor start line |
| cursor_mode_o | output | 2 | Cursor blink flags |
| cursor_end_o | output | 5 | Cursor end line |
| start_addr_o | output | 14 | Display start address |
| cursor_addr_o | output | 14 | Cursor address |

## Verification
The hardest case is a light pen strobe that arrives in the same cycle as a read of register 17. The clear and the set then compete at one edge. The bench holds `lpen_i` high over the read cycle with an unchanged refresh address, then reads the status byte to confirm the flag survived. It then repeats the read without the strobe to confirm the clear. Writes to registers 16 and 20 check that they are ignored: register 20 aliases register 4 in its low bits, and the bench observes the vertical total output and the register 16 readback.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int RA_W    = 14;
  localparam int SEL_W   = 5;
  localparam int N_WREG  = 16;
  localparam int HI_W    = RA_W - 8;

  typedef enum logic [1:0] {
    ILACE_OFF  = 2'd0,
    ILACE_SYNC = 2'd1,
    ILACE_FULL = 2'd2
  } ilace_e;

  typedef logic [N_WREG-1:0][7:0] reg_bank_t;

  function automatic logic [7:0] reg_mask(int idx);
    case (idx)
      4, 6, 7, 10: reg_mask = 8'h7f;
      5, 9, 11:    reg_mask = 8'h1f;
      12, 14:      reg_mask = 8'(8'hff >> (8 - HI_W));
      default:     reg_mask = 8'hff;
    endcase
  endfunction
endpackage

// File: rtl/crtc_reg_bank.sv
module crtc_reg_bank
  import crtc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] idx_i,
  input  logic [7:0]       wdata_i,
  output reg_bank_t        regs_o
);
  for (genvar i = 0; i < N_WREG; i++) begin : g_reg
    localparam logic [7:0] MASK = reg_mask(i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                regs_o[i] <= '0;
      else if (we_i && idx_i == SEL_W'(i))        regs_o[i] <= wdata_i & MASK;
    end
  end

  // R2
  reg4_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx_i == SEL_W'(4)) |=> regs_o[4] == {1'b0, $past(wdata_i[6:0])});
  // R10
  high_idx_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx_i >= SEL_W'(N_WREG)) |=> $stable(regs_o));
endmodule

// File: rtl/crtc_lpen.sv
module crtc_lpen
  import crtc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            strobe_i,
  input  logic [RA_W-1:0] addr_i,
  input  logic            clr_i,
  output logic [RA_W-1:0] addr_o,
  output logic            flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      flag_o <= 1'b0;
    end else begin
      if (strobe_i) addr_o <= addr_i;
      // set has priority over clear-on-read
      if (strobe_i)   flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
    end
  end

  // R5
  lpen_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> flag_o && addr_o == $past(addr_i));
  // R6
  lpen_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !strobe_i) |=> !flag_o);
endmodule

// File: rtl/crtc_field_decode.sv
module crtc_field_decode
  import crtc_pkg::*;
(
  input  reg_bank_t       regs_i,
  output logic [7:0]      h_total_o,
  output logic [7:0]      h_disp_o,
  output logic [7:0]      h_sync_pos_o,
  output logic [3:0]      h_sync_width_o,
  output logic [3:0]      v_sync_lines_o,
  output logic [6:0]      v_total_o,
  output logic [4:0]      v_adjust_o,
  output logic [6:0]      v_disp_o,
  output logic [6:0]      v_sync_pos_o,
  output ilace_e          interlace_o,
  output logic [1:0]      skew_o,
  output logic [4:0]      max_row_o,
  output logic [4:0]      cursor_start_o,
  output logic [1:0]      cursor_mode_o,
  output logic [4:0]      cursor_end_o,
  output logic [RA_W-1:0] start_addr_o,
  output logic [RA_W-1:0] cursor_addr_o
);
  logic unused_bits;

  always_comb begin
    h_total_o      = regs_i[0];
    h_disp_o       = regs_i[1];
    h_sync_pos_o   = regs_i[2];
    h_sync_width_o = regs_i[3][3:0];
    v_sync_lines_o = regs_i[3][7:4];
    v_total_o      = regs_i[4][6:0];
    v_adjust_o     = regs_i[5][4:0];
    v_disp_o       = regs_i[6][6:0];
    v_sync_pos_o   = regs_i[7][6:0];
    max_row_o      = regs_i[9][4:0];
    cursor_start_o = regs_i[10][4:0];
    cursor_mode_o  = regs_i[10][6:5];
    cursor_end_o   = regs_i[11][4:0];
    start_addr_o   = {regs_i[12][HI_W-1:0], regs_i[13]};
    cursor_addr_o  = {regs_i[14][HI_W-1:0], regs_i[15]};
    case (regs_i[8][1:0])
      2'b01:   interlace_o = ILACE_SYNC;
      2'b11:   interlace_o = ILACE_FULL;
      default: interlace_o = ILACE_OFF;
    endcase
    case (regs_i[8][5:4])
      2'b01:   skew_o = 2'd1;
      2'b10:   skew_o = 2'd2;
      default: skew_o = 2'd0;
    endcase
    unused_bits = ^{regs_i[4][7], regs_i[5][7:5], regs_i[6][7], regs_i[7][7],
                    regs_i[8][7:6], regs_i[8][3:2], regs_i[9][7:5], regs_i[10][7],
                    regs_i[11][7:5], regs_i[12][7:HI_W], regs_i[14][7:HI_W]};
  end
endmodule

// File: rtl/crtc_regfile.sv
module crtc_regfile
  import crtc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_i,
  input  logic            rs_i,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic [7:0]      wdata_i,
  output logic [7:0]      rdata_o,
  input  logic            lpen_i,
  input  logic [RA_W-1:0] refresh_addr_i,
  input  logic            vsync_i,
  output logic [7:0]      h_total_o,
  output logic [7:0]      h_disp_o,
  output logic [7:0]      h_sync_pos_o,
  output logic [3:0]      h_sync_width_o,
  output logic [3:0]      v_sync_lines_o,
  output logic [6:0]      v_total_o,
  output logic [4:0]      v_adjust_o,
  output logic [6:0]      v_disp_o,
  output logic [6:0]      v_sync_pos_o,
  output logic [1:0]      interlace_o,
  output logic [1:0]      skew_o,
  output logic [4:0]      max_row_o,
  output logic [4:0]      cursor_start_o,
  output logic [1:0]      cursor_mode_o,
  output logic [4:0]      cursor_end_o,
  output logic [RA_W-1:0] start_addr_o,
  output logic [RA_W-1:0] cursor_addr_o
);
  localparam logic [SEL_W-1:0] PEN_HI = SEL_W'(16);
  localparam logic [SEL_W-1:0] PEN_LO = SEL_W'(17);
  localparam logic [SEL_W-1:0] RD_LO  = SEL_W'(12);

  logic [SEL_W-1:0] sel_q;
  logic             sel_we, data_we, data_rd, stat_rd, pen_clr, pen_flag;
  logic [RA_W-1:0]  pen_addr;
  logic [7:0]       rd_mux;
  reg_bank_t        regs;
  ilace_e           ilace;

  assign sel_we  = cs_i && wr_i && !rs_i;
  assign data_we = cs_i && wr_i && rs_i;
  assign data_rd = cs_i && rd_i && rs_i;
  assign stat_rd = cs_i && rd_i && !rs_i;
  assign pen_clr = data_rd && (sel_q == PEN_HI || sel_q == PEN_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= '0;
    else if (sel_we) sel_q <= wdata_i[SEL_W-1:0];
  end

  crtc_reg_bank u_bank (
    .clk_i, .rst_ni, .we_i(data_we), .idx_i(sel_q), .wdata_i, .regs_o(regs)
  );

  crtc_lpen u_lpen (
    .clk_i, .rst_ni, .strobe_i(lpen_i), .addr_i(refresh_addr_i),
    .clr_i(pen_clr), .addr_o(pen_addr), .flag_o(pen_flag)
  );

  crtc_field_decode u_dec (
    .regs_i(regs), .h_total_o, .h_disp_o, .h_sync_pos_o, .h_sync_width_o,
    .v_sync_lines_o, .v_total_o, .v_adjust_o, .v_disp_o, .v_sync_pos_o,
    .interlace_o(ilace), .skew_o, .max_row_o, .cursor_start_o, .cursor_mode_o,
    .cursor_end_o, .start_addr_o, .cursor_addr_o
  );
  assign interlace_o = ilace;

  always_comb begin
    if (!rs_i)                 rd_mux = {1'b0, pen_flag, vsync_i, 5'b0};
    else if (sel_q == PEN_HI)  rd_mux = 8'(pen_addr[RA_W-1:8]);
    else if (sel_q == PEN_LO)  rd_mux = pen_addr[7:0];
    else if (sel_q >= RD_LO && sel_q < PEN_HI) rd_mux = regs[sel_q[3:0]];
    else                       rd_mux = 8'hff;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   rdata_o <= '0;
    else if (data_rd || stat_rd)   rdata_o <= rd_mux;
  end

  // R1
  sel_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_we |=> sel_q == $past(wdata_i[SEL_W-1:0]));
  // R4
  unreadable_ff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && (sel_q < RD_LO || sel_q > PEN_LO)) |=> rdata_o == 8'hff);
  // R7
  status_vsync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd |=> rdata_o[5] == $past(vsync_i) && rdata_o[4:0] == 5'b0);
endmodule

// File: tb/crtc_regfile_tb.sv
module crtc_regfile_tb;
  logic clk = 0, rst_n = 0;
  logic cs = 0, rs = 0, wr = 0, rd = 0, lpen = 0, vsync = 0;
  logic [7:0] wdata = 0, rdata;
  logic [13:0] ra = 0;
  logic [7:0] h_total, h_disp, h_sync_pos;
  logic [3:0] h_sw, v_sl;
  logic [6:0] v_total, v_disp, v_sync_pos;
  logic [4:0] v_adj, max_row, c_start, c_end;
  logic [1:0] ilace, skew, c_mode;
  logic [13:0] start_a, cursor_a;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  crtc_regfile u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rs_i(rs), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .lpen_i(lpen), .refresh_addr_i(ra),
    .vsync_i(vsync), .h_total_o(h_total), .h_disp_o(h_disp),
    .h_sync_pos_o(h_sync_pos), .h_sync_width_o(h_sw), .v_sync_lines_o(v_sl),
    .v_total_o(v_total), .v_adjust_o(v_adj), .v_disp_o(v_disp),
    .v_sync_pos_o(v_sync_pos), .interlace_o(ilace), .skew_o(skew),
    .max_row_o(max_row), .cursor_start_o(c_start), .cursor_mode_o(c_mode),
    .cursor_end_o(c_end), .start_addr_o(start_a), .cursor_addr_o(cursor_a)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus(logic r, logic w, logic d, logic [7:0] v);
    @(negedge clk);
    cs = 1; rs = r; wr = w; rd = d; wdata = v;
    @(negedge clk);
    cs = 0; wr = 0; rd = 0;
  endtask

  task automatic wreg(logic [4:0] s, logic [7:0] v);
    bus(0, 1, 0, {3'b0, s});
    bus(1, 1, 0, v);
  endtask

  task automatic rreg(logic [4:0] s);
    bus(0, 1, 0, {3'b0, s});
    bus(1, 0, 1, 8'h00);
  endtask

  // {sel, wdata, expected readback}
  localparam logic [20:0] VEC [8] = '{
    {5'd12, 8'hff, 8'h3f}, {5'd13, 8'ha5, 8'ha5},
    {5'd14, 8'hc3, 8'h03}, {5'd15, 8'h5a, 8'h5a},
    {5'd0,  8'h77, 8'hff}, {5'd9,  8'h1f, 8'hff},
    {5'd18, 8'h12, 8'hff}, {5'd31, 8'h00, 8'hff}
  };

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog expired");
      end
      begin
        #20 rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk("R11 rdata", rdata, 0);
        chk("R11 v_total", v_total, 0);
        chk("R11 start", start_a, 0);
        bus(1, 0, 1, 0);
        chk("R11 sel0 read", rdata, 8'hff);
        bus(0, 0, 1, 0);
        chk("R11 status", rdata, 0);

        for (int i = 0; i < 8; i++) begin
          wreg(VEC[i][20:16], VEC[i][15:8]);
          bus(1, 0, 1, 0);
          chk("R4/R2 readback", rdata, VEC[i][7:0]);
        end
        chk("R2 start addr", start_a, 14'h3fa5);
        chk("R2 cursor addr", cursor_a, 14'h035a);
        chk("R1/R2 h_total", h_total, 8'h77);
        chk("R2 max_row", max_row, 5'h1f);

        wreg(4, 8'hff);  chk("R2 v_total", v_total, 7'h7f);
        wreg(5, 8'hff);  chk("R2 v_adj", v_adj, 5'h1f);
        wreg(6, 8'hff);  chk("R2 v_disp", v_disp, 7'h7f);
        wreg(7, 8'hd5);  chk("R2 v_sync_pos", v_sync_pos, 7'h55);
        wreg(10, 8'hc9); chk("R2 c_start", c_start, 5'h09);
        chk("R2 c_mode", c_mode, 2'd2);
        wreg(11, 8'hee); chk("R2 c_end", c_end, 5'h0e);
        wreg(1, 8'hb2);  chk("R2 h_disp", h_disp, 8'hb2);
        wreg(2, 8'h9d);  chk("R2 h_sync_pos", h_sync_pos, 8'h9d);

        wreg(3, 8'h9c);
        chk("R3 hsync width", h_sw, 4'hc);
        chk("R3 vsync lines", v_sl, 4'h9);

        wreg(8, 8'h11); chk("R8 sync", ilace, 1); chk("R9 skew1", skew, 1);
        wreg(8, 8'h23); chk("R8 full", ilace, 2); chk("R9 skew2", skew, 2);
        wreg(8, 8'h32); chk("R8 off10", ilace, 0); chk("R9 skew3", skew, 0);
        wreg(8, 8'h00); chk("R8 off00", ilace, 0); chk("R9 skew0", skew, 0);

        // R10: reg 20 aliases reg 4 in its low bits
        wreg(20, 8'h00); chk("R10 v_total kept", v_total, 7'h7f);
        wreg(16, 8'h55); bus(1, 0, 1, 0); chk("R10 reg16 kept", rdata, 8'h00);
        wreg(17, 8'h55); bus(1, 0, 1, 0); chk("R10 reg17 kept", rdata, 8'h00);

        // R5 light pen capture
        @(negedge clk); ra = 14'h2a5c; lpen = 1;
        @(negedge clk); lpen = 0;
        bus(0, 0, 1, 0); chk("R5/R7 flag set", rdata, 8'h40);
        rreg(16); chk("R5 pen hi", rdata, 8'h2a);
        bus(0, 0, 1, 0); chk("R6 cleared by 16", rdata, 8'h00);

        // R6 same-cycle strobe keeps flag
        @(negedge clk); ra = 14'h1234; lpen = 1;
        @(negedge clk); lpen = 0;
        bus(0, 1, 0, 8'd17);
        @(negedge clk); cs = 1; rs = 1; rd = 1; lpen = 1;
        @(negedge clk); cs = 0; rd = 0; lpen = 0;
        chk("R5 pen lo", rdata, 8'h34);
        bus(0, 0, 1, 0); chk("R6 strobe wins", rdata, 8'h40);
        bus(1, 0, 1, 0); chk("R5 pen lo again", rdata, 8'h34);
        bus(0, 0, 1, 0); chk("R6 cleared by 17", rdata, 8'h00);

        vsync = 1;
        bus(0, 0, 1, 0); chk("R7 vsync bit", rdata, 8'h20);
        vsync = 0;
        bus(0, 0, 1, 0); chk("R7 vsync low", rdata, 8'h00);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule